// File: doc/BRIEF.md
# Flash Status Polling Generator

This block forms the byte returned to the host on every read of a flash device. While the array is idle, reads pass the array data straight through. While the program/erase engine is working or suspended, reads return a status byte instead. That status byte carries five things:

- a polling bit whose meaning depends on the operation under way;
- two toggle bits that change from read to read;
- an error flag;
- an erase-timer bit.

A separate one-shot reports an erase whose target blocks are all protected. It forces a fixed status for a window of about 100 µs, and the length of that window is derived from the clock frequency.

The engine reports its activity on a 3-bit code:

| Code | Meaning |
|------|---------|
| 0 | idle |
| 1 | program |
| 2 | erase |
| 3 | erase suspended |
| 4 | program while suspended |
| 5 | error |

Codes 6 and 7 are treated as idle. The engine also provides the byte being programmed, a flag telling whether the read address lies inside the block under erase, the state of the block-erase queue window, and a one-cycle request for the all-protected pulse.

Internally, a state machine tracks the engine code and has seven states: ARRAY, PROG, ERASE, SUSP, SPROG, ERR and PROT. Its transitions are as follows:

- Named transitions are *start-protect* (ARRAY to PROT on the request) and *protect-expire* (PROT to ARRAY when the timer runs out).
- All other transitions are *follow-code*: the state takes the value decoded from the engine code in the next cycle.
- On *enter-error* (any non-ERR state to ERR), the machine records whether the failure came from an erase.

The polling bit sits at position 7 and the toggle bits at 6 and 2. The error flag is at 5 and the erase-timer bit at 3. Positions 4, 1 and 0 are reserved.

Top module: `flash_poll_gen`

## Requirements
- R1: After reset and whenever the state is ARRAY, `rd_data` equals `array_data`. Reset leaves the state at ARRAY with both toggle bits at 0.
- R2: In program (code 1), the status byte shows the inverse of `prog_data[7]` on bit 7, with bit 5 = 0 and bit 3 = 0.
- R3: Bit 6 inverts after each cycle with `rd_strobe` high in states PROG, ERASE, SPROG, ERR and PROT, and holds in SUSP. Both toggle bits return to 0 in ARRAY, so the first status read of an operation shows 0 on bit 6 and bit 2.
- R4: In erase (code 2), bit 7 = 0 and bit 5 = 0. Bit 3 is 0 while `window_open` is high and 1 otherwise.
- R5: Bit 2 inverts after a strobed cycle only in ERASE or SUSP with `in_erase_blk` high. In all other cases it holds.
- R6: In suspend (code 3), a read with `in_erase_blk` high returns status with bit 7 = 1, bit 3 = 1 and bit 5 = 0. A read with it low returns `array_data`. Going from erase to suspend therefore turns bit 7 from 0 to 1.
- R7: In program-while-suspended (code 4), bits 7, 5 and 3 follow R2.
- R8: In error (code 5), bit 5 = 1. If the state before the error was ERASE or SUSP, bit 7 = 0 and bit 3 = 1. Otherwise bit 7 is the inverse of `prog_data[7]` and bit 3 = 0.
- R9: A `prot_req` seen in state ARRAY forces status with bit 7 = 0, bit 5 = 0 and bit 3 = 0 for exactly (CLK_HZ/1e6)·PROT_US cycles, then returns to ARRAY. The engine code is ignored during that window.
- R10: Bits 4, 1 and 0 are 0 whenever a status byte is shown.
- R11: A change of `eng_code` reaches `rd_data` one clock after the edge that samples it. Toggle bits change after the edge that ends a strobed cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| eng_code | input | 3 | Engine activity code (0 idle, 1 program, 2 erase, 3 suspend, 4 suspend-program, 5 error) |
| prot_req | input | 1 | One-cycle request for the all-protected pulse |
| prog_data | input | 8 | Byte being programmed |
| array_data | input | 8 | Data read from the array |
| in_erase_blk | input | 1 | Read address lies inside the block being erased |
| window_open | input | 1 | Block-erase queue window still open |
| rd_strobe | input | 1 | One cycle per host read |
| rd_data | output | 8 | Byte returned to the host |

## Verification
The assertions assume a few things about the inputs:

- `eng_code` only takes the six defined values;
- `prot_req` arrives only while the engine is idle;
- when the toggle property is checked, the engine code is held steady across the strobed cycle.

The stimulus respects these assumptions by design. It changes inputs only at falling edges, asserts the protect request from the idle state, and holds each engine code for whole sweeps. The sweeps cover every value of the programmed byte and every combination of the window, in-block and strobe inputs.

// File: rtl/flash_poll_pkg.sv
package flash_poll_pkg;

    typedef enum logic [2:0] {
        ST_ARRAY = 3'd0,
        ST_PROG  = 3'd1,
        ST_ERASE = 3'd2,
        ST_SUSP  = 3'd3,
        ST_SPROG = 3'd4,
        ST_ERR   = 3'd5,
        ST_PROT  = 3'd6
    } poll_st_e;

    localparam logic [2:0] ENG_IDLE  = 3'd0;
    localparam logic [2:0] ENG_PROG  = 3'd1;
    localparam logic [2:0] ENG_ERASE = 3'd2;
    localparam logic [2:0] ENG_SUSP  = 3'd3;
    localparam logic [2:0] ENG_SPROG = 3'd4;
    localparam logic [2:0] ENG_ERR   = 3'd5;

    localparam int BIT_POLL  = 7;
    localparam int BIT_TGL_A = 6;
    localparam int BIT_ERR   = 5;
    localparam int BIT_TIMER = 3;
    localparam int BIT_TGL_B = 2;

    function automatic poll_st_e decode_code(input logic [2:0] code);
        poll_st_e s;
        unique case (code)
            ENG_PROG:  s = ST_PROG;
            ENG_ERASE: s = ST_ERASE;
            ENG_SUSP:  s = ST_SUSP;
            ENG_SPROG: s = ST_SPROG;
            ENG_ERR:   s = ST_ERR;
            default:   s = ST_ARRAY;
        endcase
        return s;
    endfunction

endpackage

// File: rtl/flash_poll_prot_timer.sv
module flash_poll_prot_timer #(
    parameter int CYC = 5000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic expire
);
    localparam int CW = (CYC > 1) ? $clog2(CYC + 1) : 1;
    localparam logic [CW-1:0] LOAD = CW'(CYC - 1);

    logic [CW-1:0] cnt;
    logic          active;

    assign expire = active && (cnt == '0);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active <= 1'b0;
            cnt    <= '0;
        end else if (start) begin
            active <= 1'b1;
            cnt    <= LOAD;
        end else if (expire) begin
            active <= 1'b0;
        end else if (active) begin
            cnt <= cnt - 1'b1;
        end
    end
endmodule

// File: rtl/flash_poll_fsm.sv
module flash_poll_fsm
    import flash_poll_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic [2:0] eng_code,
    input  logic       prot_req,
    input  logic       expire,
    output poll_st_e   st,
    output logic       err_erase,
    output logic       prot_start
);
    poll_st_e nxt;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st        <= ST_ARRAY;
            err_erase <= 1'b0;
        end else begin
            st <= nxt;
            if (nxt == ST_ERR && st != ST_ERR)
                err_erase <= (st == ST_ERASE) || (st == ST_SUSP);
        end
    end

    // next state and outputs
    always_comb begin
        prot_start = 1'b0;
        nxt        = st;
        unique case (st)
            ST_ARRAY: begin
                if (prot_req) begin
                    prot_start = 1'b1;
                    nxt        = ST_PROT;
                end else begin
                    nxt = decode_code(eng_code);
                end
            end
            ST_PROT: begin
                nxt = expire ? ST_ARRAY : ST_PROT;
            end
            ST_PROG, ST_ERASE, ST_SUSP, ST_SPROG, ST_ERR: begin
                nxt = decode_code(eng_code);
            end
            default: nxt = ST_ARRAY;
        endcase
    end
endmodule

// File: rtl/flash_poll_toggle.sv
module flash_poll_toggle
    import flash_poll_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  poll_st_e st,
    input  logic     rd_strobe,
    input  logic     in_erase_blk,
    output logic     tgl_a,
    output logic     tgl_b
);
    logic busy_a;
    logic step_b;

    always_comb begin
        unique case (st)
            ST_PROG, ST_ERASE, ST_SPROG, ST_ERR, ST_PROT: busy_a = 1'b1;
            default:                                      busy_a = 1'b0;
        endcase
        step_b = ((st == ST_ERASE) || (st == ST_SUSP)) && in_erase_blk;
    end

    always_ff @(posedge clk) begin
        if (!rst_n || st == ST_ARRAY) begin
            tgl_a <= 1'b0;
            tgl_b <= 1'b0;
        end else if (rd_strobe) begin
            if (busy_a) tgl_a <= ~tgl_a;
            if (step_b) tgl_b <= ~tgl_b;
        end
    end
endmodule

// File: rtl/flash_poll_status.sv
module flash_poll_status
    import flash_poll_pkg::*;
(
    input  poll_st_e   st,
    input  logic       err_erase,
    input  logic       tgl_a,
    input  logic       tgl_b,
    input  logic [7:0] prog_data,
    input  logic [7:0] array_data,
    input  logic       in_erase_blk,
    input  logic       window_open,
    output logic [7:0] rd_data
);
    logic [7:0] stat;
    logic       show;

    always_comb begin
        stat             = '0;
        stat[BIT_TGL_A]  = tgl_a;
        stat[BIT_TGL_B]  = tgl_b;
        show             = 1'b1;
        unique case (st)
            ST_ARRAY: show = 1'b0;
            ST_PROG, ST_SPROG: begin
                stat[BIT_POLL] = ~prog_data[7];
            end
            ST_ERASE: begin
                stat[BIT_POLL]  = 1'b0;
                stat[BIT_TIMER] = ~window_open;
            end
            ST_SUSP: begin
                show            = in_erase_blk;
                stat[BIT_POLL]  = 1'b1;
                stat[BIT_TIMER] = 1'b1;
            end
            ST_ERR: begin
                stat[BIT_ERR]   = 1'b1;
                stat[BIT_POLL]  = err_erase ? 1'b0 : ~prog_data[7];
                stat[BIT_TIMER] = err_erase;
            end
            ST_PROT: begin
                stat[BIT_POLL] = 1'b0;
            end
            default: show = 1'b0;
        endcase
        rd_data = show ? stat : array_data;
    end
endmodule

// File: rtl/flash_poll_gen.sv
module flash_poll_gen
    import flash_poll_pkg::*;
#(
    parameter int CLK_HZ  = 50_000_000,
    parameter int PROT_US = 100
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [2:0] eng_code,
    input  logic       prot_req,
    input  logic [7:0] prog_data,
    input  logic [7:0] array_data,
    input  logic       in_erase_blk,
    input  logic       window_open,
    input  logic       rd_strobe,
    output logic [7:0] rd_data
);
    localparam int CYC_PER_US = (CLK_HZ / 1_000_000 > 0) ? CLK_HZ / 1_000_000 : 1;
    localparam int PROT_CYC   = (CYC_PER_US * PROT_US > 0) ? CYC_PER_US * PROT_US : 1;

    poll_st_e st;
    logic     err_erase;
    logic     prot_start;
    logic     expire;
    logic     tgl_a;
    logic     tgl_b;

    flash_poll_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .eng_code   (eng_code),
        .prot_req   (prot_req),
        .expire     (expire),
        .st         (st),
        .err_erase  (err_erase),
        .prot_start (prot_start)
    );

    flash_poll_prot_timer #(.CYC(PROT_CYC)) u_timer (
        .clk    (clk),
        .rst_n  (rst_n),
        .start  (prot_start),
        .expire (expire)
    );

    flash_poll_toggle u_tgl (
        .clk          (clk),
        .rst_n        (rst_n),
        .st           (st),
        .rd_strobe    (rd_strobe),
        .in_erase_blk (in_erase_blk),
        .tgl_a        (tgl_a),
        .tgl_b        (tgl_b)
    );

    flash_poll_status u_stat (
        .st           (st),
        .err_erase    (err_erase),
        .tgl_a        (tgl_a),
        .tgl_b        (tgl_b),
        .prog_data    (prog_data),
        .array_data   (array_data),
        .in_erase_blk (in_erase_blk),
        .window_open  (window_open),
        .rd_data      (rd_data)
    );
endmodule

// File: rtl/flash_poll_chk.sv
module flash_poll_chk
    import flash_poll_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input logic [2:0] eng_code,
    input logic [7:0] prog_data,
    input logic [7:0] array_data,
    input logic       in_erase_blk,
    input logic       window_open,
    input logic       rd_strobe,
    input logic [7:0] rd_data,
    input poll_st_e   st
);
    assert_array_pass_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_ARRAY) |-> (rd_data == array_data));

    assert_prog_poll_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_PROG) |-> (rd_data[7] == ~prog_data[7] && !rd_data[5] && !rd_data[3]));

    assert_prog_toggle_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_PROG && eng_code == ENG_PROG && rd_strobe) |=> (rd_data[6] != $past(rd_data[6])));

    assert_erase_timer_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_ERASE) |-> (!rd_data[7] && rd_data[3] == !window_open));

    assert_susp_inblk_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_SUSP && in_erase_blk) |-> (rd_data[7] && rd_data[3] && !rd_data[5]));

    assert_prot_low_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_PROT) |-> (!rd_data[7] && !rd_data[5]));

    assert_reserved_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (st != ST_ARRAY && !(st == ST_SUSP && !in_erase_blk)) |-> (rd_data[4] == 1'b0 && rd_data[1:0] == 2'b00));
endmodule

bind flash_poll_gen flash_poll_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .eng_code     (eng_code),
    .prog_data    (prog_data),
    .array_data   (array_data),
    .in_erase_blk (in_erase_blk),
    .window_open  (window_open),
    .rd_strobe    (rd_strobe),
    .rd_data      (rd_data),
    .st           (st)
);

// File: tb/tb_flash_poll_gen.sv
module tb_flash_poll_gen;
    import flash_poll_pkg::*;

    localparam int CLK_PERIOD = 10;
    localparam int CLK_HZ     = 1_000_000;
    localparam int PROT_US    = 20;
    localparam int PROT_CYC   = (CLK_HZ / 1_000_000) * PROT_US;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] eng_code = 3'd0;
    logic       prot_req = 1'b0;
    logic [7:0] prog_data = 8'h00;
    logic [7:0] array_data = 8'h00;
    logic       in_erase_blk = 1'b0;
    logic       window_open = 1'b0;
    logic       rd_strobe = 1'b0;
    logic [7:0] rd_data;

    int errs = 0;
    int n = 0;

    // bench model of the requirements
    poll_st_e ms = ST_ARRAY;
    logic     t6 = 1'b0, t2 = 1'b0, esrc = 1'b0;
    int       pcnt = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    flash_poll_gen #(.CLK_HZ(CLK_HZ), .PROT_US(PROT_US)) dut (
        .clk(clk), .rst_n(rst_n), .eng_code(eng_code), .prot_req(prot_req),
        .prog_data(prog_data), .array_data(array_data), .in_erase_blk(in_erase_blk),
        .window_open(window_open), .rd_strobe(rd_strobe), .rd_data(rd_data)
    );

    function automatic logic [7:0] exp_out();
        logic [7:0] e = '0;
        e[6] = t6;
        e[2] = t2;
        case (ms)
            ST_ARRAY: e = array_data;
            ST_PROG, ST_SPROG: e[7] = ~prog_data[7];
            ST_ERASE: e[3] = ~window_open;
            ST_SUSP: if (in_erase_blk) begin e[7] = 1'b1; e[3] = 1'b1; end
                     else e = array_data;
            ST_ERR: begin e[5] = 1'b1; e[7] = esrc ? 1'b0 : ~prog_data[7]; e[3] = esrc; end
            default: ;
        endcase
        return e;
    endfunction

    task automatic chk(input string req);
        #1;
        n++;
        if (rd_data !== exp_out()) begin
            errs++;
            $display("FAIL %s: rd_data=%02h expected %02h", req, rd_data, exp_out());
        end
    endtask

    task automatic tick();
        poll_st_e nx;
        logic n6, n2, ne;
        int np;
        n6 = t6; n2 = t2; ne = esrc; np = pcnt;
        if (ms == ST_ARRAY) begin n6 = 1'b0; n2 = 1'b0; end
        else if (rd_strobe) begin
            if (ms inside {ST_PROG, ST_ERASE, ST_SPROG, ST_ERR, ST_PROT}) n6 = ~t6;
            if ((ms == ST_ERASE || ms == ST_SUSP) && in_erase_blk) n2 = ~t2;
        end
        if (ms == ST_PROT) begin
            if (pcnt == 1) nx = ST_ARRAY; else begin nx = ST_PROT; np = pcnt - 1; end
        end else if (ms == ST_ARRAY && prot_req) begin
            nx = ST_PROT; np = PROT_CYC;
        end else begin
            case (eng_code)
                3'd1: nx = ST_PROG;
                3'd2: nx = ST_ERASE;
                3'd3: nx = ST_SUSP;
                3'd4: nx = ST_SPROG;
                3'd5: nx = ST_ERR;
                default: nx = ST_ARRAY;
            endcase
            if (nx == ST_ERR && ms != ST_ERR) ne = (ms == ST_ERASE || ms == ST_SUSP);
        end
        if (!rst_n) begin nx = ST_ARRAY; n6 = 1'b0; n2 = 1'b0; ne = 1'b0; end
        @(posedge clk);
        @(negedge clk);
        ms = nx; t6 = n6; t2 = n2; esrc = ne; pcnt = np;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errs++; n++;
        $display("FAIL watchdog: run did not finish, actual=hung expected=done");
        $display("Result: errors=%0d of %0d checks", errs, n);
        $finish;
    end

    initial begin
        repeat (3) tick();
        rst_n = 1'b1;
        // R1: reset state passes array data
        for (int v = 0; v < 8; v++) begin
            array_data = 8'(v * 53 + 1);
            chk("R1 reset/array");
            tick();
        end
        // R2 / R3 / R10: program sweep over every byte
        eng_code = 3'd1;
        chk("R11 code change not yet visible");
        tick();
        for (int v = 0; v < 256; v++) begin
            prog_data = 8'(v);
            rd_strobe = v[0] ^ v[3];
            chk("R2 R3 R10 program");
            tick();
        end
        rd_strobe = 1'b0;
        // R3: return to idle clears toggles
        eng_code = 3'd0; tick(); chk("R1 idle");
        eng_code = 3'd1; tick(); chk("R3 toggles cleared");
        // R4 / R5: erase sweep
        eng_code = 3'd2; tick();
        for (int i = 0; i < 32; i++) begin
            window_open = i[0];
            in_erase_blk = i[1];
            rd_strobe = i[2] | i[4];
            chk("R4 R5 erase");
            tick();
        end
        rd_strobe = 1'b0;
        // R6: suspend, bit 7 goes 0 -> 1
        in_erase_blk = 1'b1;
        eng_code = 3'd3;
        chk("R11 still erase");
        tick();
        for (int i = 0; i < 16; i++) begin
            in_erase_blk = i[0];
            rd_strobe = i[1];
            array_data = 8'(i * 37 + 5);
            chk("R6 R5 suspend");
            tick();
        end
        rd_strobe = 1'b0;
        // R7: program during suspend
        eng_code = 3'd4; tick();
        for (int v = 0; v < 64; v++) begin
            prog_data = 8'(v * 5);
            rd_strobe = v[1];
            chk("R7 suspend-program");
            tick();
        end
        rd_strobe = 1'b0;
        // R8: error from a program source
        eng_code = 3'd5; tick();
        for (int v = 0; v < 4; v++) begin
            prog_data = 8'(v << 6);
            rd_strobe = v[0];
            chk("R8 program error");
            tick();
        end
        rd_strobe = 1'b0;
        // R8: error from an erase source
        eng_code = 3'd0; tick();
        eng_code = 3'd2; tick();
        eng_code = 3'd5; tick();
        for (int v = 0; v < 4; v++) begin
            prog_data = 8'(v << 6);
            chk("R8 erase error");
            tick();
        end
        // R9: all-protected pulse, engine code ignored
        eng_code = 3'd0; tick();
        prot_req = 1'b1; tick();
        prot_req = 1'b0;
        eng_code = 3'd2;
        for (int i = 0; i < PROT_CYC + 4; i++) begin
            rd_strobe = i[0];
            array_data = 8'(i + 200);
            chk("R9 protect pulse");
            tick();
        end
        rd_strobe = 1'b0;
        eng_code = 3'd0; tick();
        chk("R1 final idle");
        $display("Result: errors=%0d of %0d checks", errs, n);
        $finish;
    end
endmodule